// File: doc/BRIEF.md
# Hardware Loop Sequencer

This block sits next to a program counter and lets a processor repeat a body of code without spending any instruction on the branch back. A setup strobe, issued on the fetch of a loop-setup instruction, records three things: the address of the first body instruction (the setup PC plus one), the address of the last body instruction, and an 8-bit pass count. From then on, every fetch is compared with the last-body address. A match with passes still to run sends the sequencer back to the first body instruction. Otherwise the sequencer steps forward by one.

Loops nest through a four-entry stack, and only the innermost entry is compared on each fetch. When that entry runs out of passes, or when an external early-exit condition is seen at its last-body address, it is dropped at once. The enclosing loop then takes over. A loaded count of zero gives 256 passes. A body of exactly one instruction raises an interrupt-mask output for as long as it runs.

Top module: `zol_seq`

## Requirements
- R1: After reset no loop is held: `loopActive`, `intMask` and `stackErr` are 0 and `nextPc` equals `pc + 1`.
- R2: A `setupValid` fetch with room on the stack pushes an entry with start `pc + 1`, end `setupEnd` and count `setupCount`. In that cycle `nextPc` is `pc + 1`, and `loopActive` is 1 from the next cycle.
- R3: When a loop is held, `pc` equals the innermost end address, the remaining count is above 1 and `exitCond` is 0, `nextPc` is the innermost start address and the remaining count drops by one.
- R4: A count N from 1 to 255 gives N passes through the end address. On the last pass `nextPc` is `pc + 1` and the innermost entry is removed.
- R5: A count of 0 gives 256 passes (255 loop-backs).
- R6: A fetch that matches no end address, with no setup, gives `nextPc = pc + 1` and changes no loop state. Only the innermost entry's end address is compared.
- R7: Up to four loops nest. When the innermost one ends, the enclosing loop resumes with its own start, end and remaining count.
- R8: `exitCond` at the innermost end address ends that loop at once (`nextPc = pc + 1`, entry removed). At any other fetch it has no effect.
- R9: `intMask` is 1 exactly while the innermost held loop has a start address equal to its end address (a one-instruction body).
- R10: A setup while four entries are held raises `stackErr` for one cycle, the cycle after the setup, and leaves every entry unchanged.
- R11: A setup takes priority over loop-back when both occur in the same fetch: the new loop is pushed and `nextPc` is `pc + 1`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pc | input | AW | Address of the instruction being fetched |
| setupValid | input | 1 | Fetch is a loop-setup instruction |
| setupEnd | input | AW | Last body address for the new loop |
| setupCount | input | CW | Pass count for the new loop (0 means 256) |
| exitCond | input | 1 | Early-exit condition, sampled only at the innermost end address |
| nextPc | output | AW | Address to fetch next |
| loopActive | output | 1 | At least one loop is held |
| intMask | output | 1 | Interrupts must be held off (one-instruction body running) |
| stackErr | output | 1 | One-cycle flag: setup refused because the stack was full |

## Verification
On every cycle the assertions check the following. Any redirect away from `pc + 1` needs a held loop and no setup. A setup fetch always steps forward. `intMask` implies a held loop. Stack depth never exceeds four, grows by one on an accepted setup, and stays put while the refusal flag rises. The number of passes, the handling of a zero count, early exit only at the end address, and the resumption of an outer loop's count after an inner loop ends all span many cycles. Only the bench's program runs can show these, with its behavioural model checked against every fetch.

// File: rtl/zol_pkg.sv
package zol_pkg;

  // Strobes from the control decision to the loop-stack datapath.
  typedef struct packed {
    logic push;
    logic pop;
    logic dec;
  } zolCmd_t;

endpackage

// File: rtl/zol_stack.sv
module zol_stack
  import zol_pkg::*;
#(
  parameter int AW    = 16,
  parameter int CW    = 8,
  parameter int DEPTH = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  zolCmd_t         cmd,
  input  logic [AW-1:0]   pushStart,
  input  logic [AW-1:0]   pushEnd,
  input  logic [CW-1:0]   pushCount,
  output logic [AW-1:0]   topStart,
  output logic [AW-1:0]   topEnd,
  output logic [CW-1:0]   topCount,
  output logic [$clog2(DEPTH+1)-1:0] depth,
  output logic            full,
  output logic            empty
);

  localparam int DW = $clog2(DEPTH + 1);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [AW-1:0] startMem [DEPTH];
  logic [AW-1:0] endMem   [DEPTH];
  logic [CW-1:0] countMem [DEPTH];
  logic [IW-1:0] topIdx;

  assign full   = (depth == DW'(DEPTH));
  assign empty  = (depth == '0);
  assign topIdx = IW'(depth - DW'(1));

  // Entry i is written when it is the free slot, decremented when on top.
  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        startMem[i] <= '0;
        endMem[i]   <= '0;
        countMem[i] <= '0;
      end else if (cmd.push && depth == DW'(i)) begin
        startMem[i] <= pushStart;
        endMem[i]   <= pushEnd;
        countMem[i] <= pushCount;
      end else if (cmd.dec && depth == DW'(i + 1)) begin
        countMem[i] <= countMem[i] - CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      depth <= '0;
    end else if (cmd.push && !full) begin
      depth <= depth + DW'(1);
    end else if (cmd.pop && !empty) begin
      depth <= depth - DW'(1);
    end
  end

  always_comb begin
    if (empty) begin
      topStart = '0;
      topEnd   = '0;
      topCount = '0;
    end else begin
      topStart = startMem[topIdx];
      topEnd   = endMem[topIdx];
      topCount = countMem[topIdx];
    end
  end

endmodule

// File: rtl/zol_ctrl.sv
module zol_ctrl
  import zol_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 8
) (
  input  logic [AW-1:0] pc,
  input  logic          setupValid,
  input  logic          exitCond,
  input  logic [AW-1:0] topStart,
  input  logic [AW-1:0] topEnd,
  input  logic [CW-1:0] topCount,
  input  logic          full,
  input  logic          empty,
  output zolCmd_t       cmd,
  output logic [AW-1:0] nextPc,
  output logic [AW-1:0] pushStart,
  output logic          errSet,
  output logic          maskNow
);

  logic [AW-1:0] pcInc;
  logic          atEnd;
  logic          lastPass;

  assign pcInc     = pc + AW'(1);
  assign pushStart = pcInc;
  assign atEnd     = !empty && (pc == topEnd);
  // Count 1 is the final pass; count 0 wraps to 255 on decrement, giving 256.
  assign lastPass  = (topCount == CW'(1));
  assign maskNow   = !empty && (topStart == topEnd);

  always_comb begin
    cmd    = '0;
    nextPc = pcInc;
    errSet = 1'b0;
    if (setupValid) begin
      if (full) errSet = 1'b1;
      else      cmd.push = 1'b1;
    end else if (atEnd) begin
      if (exitCond || lastPass) begin
        cmd.pop = 1'b1;
      end else begin
        cmd.dec = 1'b1;
        nextPc  = topStart;
      end
    end
  end

endmodule

// File: rtl/zol_seq.sv
module zol_seq
  import zol_pkg::*;
#(
  parameter int AW    = 16,
  parameter int CW    = 8,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] pc,
  input  logic          setupValid,
  input  logic [AW-1:0] setupEnd,
  input  logic [CW-1:0] setupCount,
  input  logic          exitCond,
  output logic [AW-1:0] nextPc,
  output logic          loopActive,
  output logic          intMask,
  output logic          stackErr
);

  localparam int DW = $clog2(DEPTH + 1);

  zolCmd_t       cmd;
  logic [AW-1:0] topStart, topEnd, pushStart;
  logic [CW-1:0] topCount;
  logic [DW-1:0] depth;
  logic          full, empty, errSet, maskNow;

  zol_ctrl #(.AW(AW), .CW(CW)) ctrl_i (
    .pc(pc), .setupValid(setupValid), .exitCond(exitCond),
    .topStart(topStart), .topEnd(topEnd), .topCount(topCount),
    .full(full), .empty(empty), .cmd(cmd), .nextPc(nextPc),
    .pushStart(pushStart), .errSet(errSet), .maskNow(maskNow)
  );

  zol_stack #(.AW(AW), .CW(CW), .DEPTH(DEPTH)) stack_i (
    .clk(clk), .rstN(rstN), .cmd(cmd), .pushStart(pushStart),
    .pushEnd(setupEnd), .pushCount(setupCount), .topStart(topStart),
    .topEnd(topEnd), .topCount(topCount), .depth(depth),
    .full(full), .empty(empty)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stackErr <= 1'b0;
    else       stackErr <= errSet;
  end

  assign loopActive = !empty;
  assign intMask    = maskNow;

endmodule

// File: rtl/zol_seq_chk.sv
module zol_seq_chk #(
  parameter int AW    = 16,
  parameter int CW    = 8,
  parameter int DEPTH = 4
) (
  input logic                       clk,
  input logic                       rstN,
  input logic [AW-1:0]              pc,
  input logic                       setupValid,
  input logic                       exitCond,
  input logic [AW-1:0]              nextPc,
  input logic                       loopActive,
  input logic                       intMask,
  input logic                       stackErr,
  input logic [$clog2(DEPTH+1)-1:0] depth
);

  localparam int DW = $clog2(DEPTH + 1);

  // R6: a redirect requires a held loop and no setup in the same fetch
  assert_redirect_needs_loop_R6: assert property (@(posedge clk) disable iff (!rstN)
    (nextPc != pc + AW'(1)) |-> (loopActive && !setupValid));

  // R11: a setup fetch always steps forward
  assert_setup_steps_R11: assert property (@(posedge clk) disable iff (!rstN)
    setupValid |-> (nextPc == pc + AW'(1)));

  // R9: interrupt mask only while a loop is held
  assert_mask_in_loop_R9: assert property (@(posedge clk) disable iff (!rstN)
    intMask |-> loopActive);

  // R7: depth bounded by the stack size
  assert_depth_bound_R7: assert property (@(posedge clk) disable iff (!rstN)
    depth <= DW'(DEPTH));

  // R2: accepted setup grows the stack by one
  assert_push_grows_R2: assert property (@(posedge clk) disable iff (!rstN)
    (setupValid && depth < DW'(DEPTH)) |=> (depth == $past(depth) + DW'(1)));

  // R10: refused setup flags and keeps depth
  assert_full_refused_R10: assert property (@(posedge clk) disable iff (!rstN)
    (setupValid && depth == DW'(DEPTH)) |=> (stackErr && depth == $past(depth)));

  // R10: flag never rises without a refused setup
  assert_err_cause_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(setupValid && depth == DW'(DEPTH)) |=> !stackErr);

  // R8: early exit outside a loop leaves nothing to act on
  assert_cond_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    (exitCond && !loopActive && !setupValid) |=> !loopActive);

endmodule

bind zol_seq zol_seq_chk #(.AW(AW), .CW(CW), .DEPTH(DEPTH)) chk_i (.*);

// File: tb/zol_seq_tb_top.sv
module zol_seq_tb_top;

  localparam int AW = 16;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [AW-1:0] pc = '0;
  logic          setupValid = 1'b0;
  logic [AW-1:0] setupEnd = '0;
  logic [CW-1:0] setupCount = '0;
  logic          exitCond = 1'b0;
  logic [AW-1:0] nextPc;
  logic          loopActive, intMask, stackErr;

  int checks = 0;
  int fails  = 0;

  // behavioural model: innermost entry is the last element
  int qStart[$];
  int qEnd[$];
  int qCnt[$];
  bit expErr = 0;

  int backs;
  int suPc[4], suEnd[4], suCnt[4];
  int suN;
  int condA, condB;

  always #10 clk = ~clk;

  zol_seq #(.AW(AW), .CW(CW), .DEPTH(4)) dut_i (
    .clk(clk), .rstN(rstN), .pc(pc), .setupValid(setupValid),
    .setupEnd(setupEnd), .setupCount(setupCount), .exitCond(exitCond),
    .nextPc(nextPc), .loopActive(loopActive), .intMask(intMask),
    .stackErr(stackErr)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; setupValid = 0; exitCond = 0;
    qStart.delete(); qEnd.delete(); qCnt.delete();
    expErr = 0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  // one fetch: drive, compare against the model, advance the model
  task automatic step(input int p, input bit sv, input int se, input int sc,
                      input bit cond, output int np);
    string tag;
    int n;
    bit act;
    @(negedge clk);
    pc = AW'(p); setupValid = sv; setupEnd = AW'(se);
    setupCount = CW'(sc); exitCond = cond;
    #5;
    n   = (p + 1) % (1 << AW);
    act = (qCnt.size() > 0);
    tag = "R6";
    if (sv) tag = act && p == qEnd[$] ? "R11" : "R2";
    else if (act && p == qEnd[$]) begin
      if (cond && qCnt[$] > 1) tag = "R8";
      else if (qCnt[$] == 1) tag = "R4";
      else begin tag = "R3"; n = qStart[$]; end
    end
    check(tag, int'(nextPc), n);
    check("R7", int'(loopActive), int'(act));
    check("R9", int'(intMask), int'(act && qStart[$] == qEnd[$]));
    check("R10", int'(stackErr), int'(expErr));
    expErr = 0;
    if (sv) begin
      if (qCnt.size() == 4) expErr = 1;
      else begin
        qStart.push_back((p + 1) % (1 << AW));
        qEnd.push_back(se);
        qCnt.push_back(sc == 0 ? 256 : sc);
      end
    end else if (act && p == qEnd[$]) begin
      if (cond || qCnt[$] == 1) begin
        void'(qStart.pop_back()); void'(qEnd.pop_back()); void'(qCnt.pop_back());
      end else qCnt[$] = qCnt[$] - 1;
    end
    np = n;
  endtask

  task automatic runProg(input int startPc, input int stopPc);
    int p = startPc;
    int cyc = 0;
    int np;
    backs = 0;
    while (p != stopPc && cyc < 5000) begin
      bit sv = 0;
      int se = 0, sc = 0;
      for (int k = 0; k < suN; k++)
        if (suPc[k] == p) begin sv = 1; se = suEnd[k]; sc = suCnt[k]; end
      step(p, sv, se, sc, (cyc == condA) || (cyc == condB), np);
      if (np != p + 1) backs++;
      p = np;
      cyc++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int np;
    condA = -1; condB = -1;
    doReset();
    #5;
    // R1: reset state
    check("R1", int'(loopActive), 0);
    check("R1", int'(intMask), 0);
    check("R1", int'(stackErr), 0);
    step(5, 0, 0, 0, 0, np);
    check("R1", np, 6);

    // R3 / R4: three-instruction body, count 3
    suN = 1; suPc[0] = 10; suEnd[0] = 13; suCnt[0] = 3;
    runProg(10, 20);
    check("R4", backs, 2);

    // R5 / R9: one-instruction body, count 0 means 256 passes
    suN = 1; suPc[0] = 100; suEnd[0] = 101; suCnt[0] = 0;
    runProg(100, 105);
    check("R5", backs, 255);

    // R7: nested loops, outer 2 passes, inner 3 passes
    suN = 2; suPc[0] = 30; suEnd[0] = 36; suCnt[0] = 2;
    suPc[1] = 32; suEnd[1] = 34; suCnt[1] = 3;
    runProg(30, 40);
    check("R7", backs, 5);

    // R8: early exit at end (cycle 6); condition at cycle 3 is off the end
    suN = 1; suPc[0] = 50; suEnd[0] = 52; suCnt[0] = 10;
    condA = 3; condB = 6;
    runProg(50, 60);
    check("R8", backs, 2);
    condA = -1; condB = -1;
    check("R8", int'(loopActive), 0);

    // R10: fifth setup refused, the four held entries remain intact
    for (int k = 0; k < 5; k++) step(200 + k, 1, 300, 1, 0, np);
    step(205, 0, 0, 0, 0, np);
    for (int k = 0; k < 4; k++) step(300, 0, 0, 0, 0, np);
    step(300, 0, 0, 0, 0, np);
    check("R10", int'(loopActive), 0);

    // R11: setup on the end address of a held loop
    step(400, 1, 402, 2, 0, np);
    step(401, 0, 0, 0, 0, np);
    step(402, 1, 410, 1, 0, np);
    check("R11", np, 403);
    doReset();
    #5;
    check("R1", int'(loopActive), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule